// File: doc/BRIEF.md
# Segment-Relative Address Offset Unit

This unit sits between the load/store pipeline of a processor and its page translation stage. It owns a private table of segment descriptors, separate from the general purpose registers, and every access the core makes (ordinary data loads and stores, instruction fetches, and explicit segment loads and stores) is turned into a segment-relative address here. No path carries an address around it.

Each descriptor holds a base, a length and three permission bits. Ordinary data traffic always goes through descriptor 0. Fetches always go through descriptor 1. Explicit segment accesses name any descriptor by index. For the chosen descriptor the unit adds the offset to the base, checks the access range against the length and checks the required permission. One clock after the request it issues either a memory request or a fault. A fault carries a cause code and the descriptor index. Descriptors are loaded through a dedicated write port.

Top module: `seg_offset_unit`

## Requirements
- R1: After reset no output is valid, and every descriptor has zero length and no permissions, so the first access through any descriptor faults with the permission cause.
- R2: Request kinds 0 (data load) and 1 (data store) always use descriptor 0, whatever `req_idx` holds.
- R3: Request kind 2 (fetch) always uses descriptor 1, needs the execute bit, and raises `mem_fetch` on success.
- R4: Request kinds 3 (segment load) and 4 (segment store) use the descriptor named by `req_idx`, including 0 and 1.
- R5: A successful access drives `mem_valid` with `mem_addr` = base + offset (modulo 2^64) exactly one cycle after the request. `mem_write` is set for kinds 1 and 4.
- R6: A bounds fault (cause 2) occurs when offset + size > length, computed without wraparound. An access that ends exactly at the length is allowed.
- R7: Permission bit 0 is read, bit 1 is write and bit 2 is execute. Loads need read, stores need write and fetches need execute. When both the permission and the bounds checks fail, the cause is permission (1).
- R8: A faulting access asserts `flt_valid` with its cause and the descriptor index, and no memory request is issued that cycle.
- R9: A descriptor write becomes visible to requests from the next cycle on. A request in the same cycle as a write to its descriptor uses the old contents.
- R10: A cycle with no request produces neither a memory request nor a fault one cycle later.
- R11: Request kinds 5 to 7 fault with cause 3 and report `req_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_we | input | 1 | Descriptor write enable |
| desc_widx | input | 5 | Descriptor to write |
| desc_wbase | input | 64 | New base |
| desc_wlen | input | 64 | New length in bytes |
| desc_wperm | input | 3 | New permissions {X,W,R} |
| req_valid | input | 1 | Access request present |
| req_kind | input | 3 | Access kind 0..4, 5..7 illegal |
| req_idx | input | 5 | Descriptor index for explicit kinds |
| req_off | input | 64 | Offset within the segment |
| req_size | input | 4 | Access size in bytes |
| mem_valid | output | 1 | Memory request toward translation |
| mem_addr | output | 64 | Segment-relative address (base + offset) |
| mem_write | output | 1 | Request is a store |
| mem_fetch | output | 1 | Request is an instruction fetch |
| flt_valid | output | 1 | Access faulted |
| flt_cause | output | 2 | 1 permission, 2 bounds, 3 illegal kind |
| flt_idx | output | 5 | Descriptor involved in the fault |

## Verification
Every result, whether a memory request or a fault, appears on the outputs one cycle after the request is presented. The driver applies each request on a falling edge and pushes its expected outcome into a queue. The monitor wakes shortly after the next rising edge and pops exactly one item for that cycle. Idle cycles push an item that expects no outputs. Descriptor writes update the bench's shadow table only after the expected outcome for the same cycle has been formed, which matches the rule that a write is visible only from the next cycle.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int SEG_AW      = 64;
    localparam int SEG_ENTRIES = 32;
    localparam int SEG_IW      = $clog2(SEG_ENTRIES);
    localparam int SEG_SW      = 4;
    localparam int SEG_PW      = 3;

    localparam logic [SEG_PW-1:0] PERM_R = 3'b001;
    localparam logic [SEG_PW-1:0] PERM_W = 3'b010;
    localparam logic [SEG_PW-1:0] PERM_X = 3'b100;

    typedef enum logic [2:0] {
        K_DLOAD  = 3'd0,
        K_DSTORE = 3'd1,
        K_FETCH  = 3'd2,
        K_SLOAD  = 3'd3,
        K_SSTORE = 3'd4
    } acc_kind_e;

    typedef enum logic [1:0] {
        C_NONE   = 2'd0,
        C_PERM   = 2'd1,
        C_BOUNDS = 2'd2,
        C_KIND   = 2'd3
    } flt_cause_e;

    typedef struct packed {
        logic [SEG_AW-1:0] base;
        logic [SEG_AW-1:0] len;
        logic [SEG_PW-1:0] perm;
    } seg_desc_t;

    function automatic logic kind_known(input logic [2:0] k);
        return k <= 3'd4;
    endfunction

    function automatic logic [SEG_PW-1:0] needed_perm(input logic [2:0] k);
        case (k)
            K_DLOAD, K_SLOAD:   return PERM_R;
            K_DSTORE, K_SSTORE: return PERM_W;
            K_FETCH:            return PERM_X;
            default:            return '0;
        endcase
    endfunction

    function automatic logic is_store(input logic [2:0] k);
        return (k == K_DSTORE) || (k == K_SSTORE);
    endfunction
endpackage

// File: rtl/seg_desc_file.sv
module seg_desc_file
    import seg_pkg::*;
#(
    parameter int N  = SEG_ENTRIES,
    parameter int IW = SEG_IW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  seg_desc_t     wdesc,
    input  logic [IW-1:0] ridx,
    output seg_desc_t     rdesc
);
    seg_desc_t entry [N];

    for (genvar g = 0; g < N; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry[g] <= '0;
            end else if (we && (widx == IW'(g))) begin
                entry[g] <= wdesc;
            end
        end
    end

    assign rdesc = entry[ridx];
endmodule

// File: rtl/seg_index_sel.sv
module seg_index_sel
    import seg_pkg::*;
#(
    parameter int IW        = SEG_IW,
    parameter int DATA_IDX  = 0,
    parameter int FETCH_IDX = 1
) (
    input  logic [2:0]    kind,
    input  logic [IW-1:0] req_idx,
    output logic [IW-1:0] sel_idx
);
    always_comb begin
        case (kind)
            K_DLOAD, K_DSTORE: sel_idx = IW'(DATA_IDX);
            K_FETCH:           sel_idx = IW'(FETCH_IDX);
            default:           sel_idx = req_idx;
        endcase
    end
endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_pkg::*;
#(
    parameter int AW = SEG_AW,
    parameter int SW = SEG_SW
) (
    input  seg_desc_t     desc,
    input  logic [2:0]    kind,
    input  logic [AW-1:0] off,
    input  logic [SW-1:0] size,
    output logic [AW-1:0] addr,
    output flt_cause_e    cause
);
    logic [AW:0]        end_pos;
    logic               over;
    logic [SEG_PW-1:0]  need;

    assign end_pos = {1'b0, off} + (AW+1)'(size);
    assign over    = end_pos > {1'b0, desc.len};
    assign need    = needed_perm(kind);
    assign addr    = desc.base + off;

    always_comb begin
        if (!kind_known(kind))             cause = C_KIND;
        else if ((desc.perm & need) != need) cause = C_PERM;
        else if (over)                     cause = C_BOUNDS;
        else                               cause = C_NONE;
    end
endmodule

// File: rtl/seg_offset_unit.sv
module seg_offset_unit
    import seg_pkg::*;
#(
    parameter int AW        = SEG_AW,
    parameter int IW        = SEG_IW,
    parameter int SW        = SEG_SW,
    parameter int PW        = SEG_PW,
    parameter int DATA_IDX  = 0,
    parameter int FETCH_IDX = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          desc_we,
    input  logic [IW-1:0] desc_widx,
    input  logic [AW-1:0] desc_wbase,
    input  logic [AW-1:0] desc_wlen,
    input  logic [PW-1:0] desc_wperm,
    input  logic          req_valid,
    input  logic [2:0]    req_kind,
    input  logic [IW-1:0] req_idx,
    input  logic [AW-1:0] req_off,
    input  logic [SW-1:0] req_size,
    output logic          mem_valid,
    output logic [AW-1:0] mem_addr,
    output logic          mem_write,
    output logic          mem_fetch,
    output logic          flt_valid,
    output logic [1:0]    flt_cause,
    output logic [IW-1:0] flt_idx
);
    seg_desc_t     wdesc, rdesc;
    logic [IW-1:0] sel_idx;
    logic [AW-1:0] calc_addr;
    flt_cause_e    cause;

    assign wdesc = '{base: desc_wbase, len: desc_wlen, perm: desc_wperm};

    seg_desc_file #(.N(SEG_ENTRIES), .IW(IW)) u_file (
        .clk(clk), .rst(rst), .we(desc_we), .widx(desc_widx),
        .wdesc(wdesc), .ridx(sel_idx), .rdesc(rdesc)
    );

    seg_index_sel #(.IW(IW), .DATA_IDX(DATA_IDX), .FETCH_IDX(FETCH_IDX)) u_sel (
        .kind(req_kind), .req_idx(req_idx), .sel_idx(sel_idx)
    );

    seg_check #(.AW(AW), .SW(SW)) u_chk (
        .desc(rdesc), .kind(req_kind), .off(req_off), .size(req_size),
        .addr(calc_addr), .cause(cause)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_valid <= 1'b0;
            mem_addr  <= '0;
            mem_write <= 1'b0;
            mem_fetch <= 1'b0;
            flt_valid <= 1'b0;
            flt_cause <= '0;
            flt_idx   <= '0;
        end else begin
            mem_valid <= req_valid && (cause == C_NONE);
            mem_addr  <= calc_addr;
            mem_write <= req_valid && (cause == C_NONE) && is_store(req_kind);
            mem_fetch <= req_valid && (cause == C_NONE) && (req_kind == K_FETCH);
            flt_valid <= req_valid && (cause != C_NONE);
            flt_cause <= req_valid ? cause : C_NONE;
            flt_idx   <= sel_idx;
        end
    end

    p_one_outcome_r8: assert property (@(posedge clk) disable iff (rst)
        !(mem_valid && flt_valid));
    p_resp_next_r5: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (mem_valid || flt_valid));
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!mem_valid && !flt_valid));
    p_fault_cause_r8: assert property (@(posedge clk) disable iff (rst)
        flt_valid |-> (flt_cause != 2'd0));
    p_data_entry_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind <= 3'd1) |=> (!flt_valid || flt_idx == IW'(DATA_IDX)));
    p_fetch_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 3'd2) |=> (!mem_valid || (mem_fetch && !mem_write)));
endmodule

// File: tb/seg_offset_unit_tb.sv
module seg_offset_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        desc_we = 1'b0;
    logic [4:0]  desc_widx = '0;
    logic [63:0] desc_wbase = '0, desc_wlen = '0;
    logic [2:0]  desc_wperm = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [4:0]  req_idx = '0;
    logic [63:0] req_off = '0;
    logic [3:0]  req_size = '0;
    logic        mem_valid, mem_write, mem_fetch, flt_valid;
    logic [63:0] mem_addr;
    logic [1:0]  flt_cause;
    logic [4:0]  flt_idx;

    int checks = 0, errors = 0;
    bit done = 0;

    typedef struct {
        bit          mv;
        logic [63:0] addr;
        bit          mw, mf, fv;
        logic [1:0]  cause;
        logic [4:0]  idx;
        string       tag;
    } exp_t;
    exp_t q[$];

    logic [63:0] sh_base [32];
    logic [63:0] sh_len  [32];
    logic [2:0]  sh_perm [32];

    always #5 clk = ~clk;

    seg_offset_unit u_dut (
        .clk(clk), .rst(rst), .desc_we(desc_we), .desc_widx(desc_widx),
        .desc_wbase(desc_wbase), .desc_wlen(desc_wlen), .desc_wperm(desc_wperm),
        .req_valid(req_valid), .req_kind(req_kind), .req_idx(req_idx),
        .req_off(req_off), .req_size(req_size),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_write(mem_write),
        .mem_fetch(mem_fetch), .flt_valid(flt_valid), .flt_cause(flt_cause),
        .flt_idx(flt_idx)
    );

    function automatic exp_t model(bit r, logic [2:0] k, logic [4:0] ri,
                                   logic [63:0] off, logic [3:0] sz, string tag);
        exp_t e;
        logic [4:0]  ix;
        logic [2:0]  need;
        logic [64:0] fin;
        e = '{mv: 0, addr: '0, mw: 0, mf: 0, fv: 0, cause: 2'd0, idx: '0, tag: tag};
        if (!r) return e;
        ix   = (k <= 3'd1) ? 5'd0 : (k == 3'd2) ? 5'd1 : ri;
        need = (k == 3'd0 || k == 3'd3) ? 3'b001 :
               (k == 3'd1 || k == 3'd4) ? 3'b010 : 3'b100;
        fin  = {1'b0, off} + {61'd0, sz};
        if (k > 3'd4)                          e.cause = 2'd3;
        else if ((sh_perm[ix] & need) != need) e.cause = 2'd1;
        else if (fin > {1'b0, sh_len[ix]})     e.cause = 2'd2;
        if (e.cause != 2'd0) begin
            e.fv = 1; e.idx = ix;
        end else begin
            e.mv = 1; e.addr = sh_base[ix] + off;
            e.mw = (k == 3'd1 || k == 3'd4); e.mf = (k == 3'd2);
        end
        return e;
    endfunction

    task automatic step(bit w, logic [4:0] wi, logic [63:0] wb, logic [63:0] wl,
                        logic [2:0] wp, bit r, logic [2:0] k, logic [4:0] ri,
                        logic [63:0] off, logic [3:0] sz, string tag);
        @(negedge clk);
        desc_we = w; desc_widx = wi; desc_wbase = wb; desc_wlen = wl; desc_wperm = wp;
        req_valid = r; req_kind = k; req_idx = ri; req_off = off; req_size = sz;
        q.push_back(model(r, k, ri, off, sz, tag));
        if (w) begin
            sh_base[wi] = wb; sh_len[wi] = wl; sh_perm[wi] = wp;
        end
    endtask

    task automatic wr(logic [4:0] wi, logic [63:0] wb, logic [63:0] wl, logic [2:0] wp);
        step(1, wi, wb, wl, wp, 0, 3'd0, 5'd0, 64'd0, 4'd0, "R9 write");
    endtask

    task automatic acc(logic [2:0] k, logic [4:0] ri, logic [63:0] off,
                       logic [3:0] sz, string tag);
        step(0, 5'd0, 64'd0, 64'd0, 3'd0, 1, k, ri, off, sz, tag);
    endtask

    task automatic idle(string tag);
        step(0, 5'd0, 64'd0, 64'd0, 3'd0, 0, 3'd0, 5'd0, 64'd0, 4'd0, tag);
    endtask

    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            bit bad;
            e = q.pop_front();
            checks++;
            bad = (mem_valid !== e.mv) || (flt_valid !== e.fv) ||
                  (e.mv && (mem_addr !== e.addr || mem_write !== e.mw || mem_fetch !== e.mf)) ||
                  (e.fv && (flt_cause !== e.cause || flt_idx !== e.idx));
            if (bad) begin
                errors++;
                $display("FAIL %s: got mv=%0b addr=%h mw=%0b mf=%0b fv=%0b cause=%0d idx=%0d, expected mv=%0b addr=%h mw=%0b mf=%0b fv=%0b cause=%0d idx=%0d",
                         e.tag, mem_valid, mem_addr, mem_write, mem_fetch, flt_valid,
                         flt_cause, flt_idx, e.mv, e.addr, e.mw, e.mf, e.fv, e.cause, e.idx);
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            sh_base[i] = '0; sh_len[i] = '0; sh_perm[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (mem_valid !== 1'b0 || flt_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got mv=%0b fv=%0b, expected 0 0", mem_valid, flt_valid);
        end
        // R1: cleared descriptors fault on permission
        acc(3'd0, 5'd0, 64'd0, 4'd0, "R1 data after reset");
        acc(3'd3, 5'd17, 64'd0, 4'd1, "R1 explicit after reset");
        // R2 / R5: data kinds use entry 0 only
        wr(5'd0, 64'h1000, 64'h100, 3'b011);
        wr(5'd7, 64'h9000_0000, 64'h100, 3'b011);
        acc(3'd0, 5'd7, 64'h10, 4'd8, "R2 R5 data load ignores idx");
        acc(3'd1, 5'd7, 64'h20, 4'd4, "R2 R5 data store");
        // R6: exact end allowed, one past faults
        acc(3'd0, 5'd0, 64'hF8, 4'd8, "R6 end at length");
        acc(3'd0, 5'd0, 64'hF9, 4'd8, "R6 one byte over");
        wr(5'd5, 64'h40, 64'hFFFF_FFFF_FFFF_FFFF, 3'b111);
        acc(3'd3, 5'd5, 64'hFFFF_FFFF_FFFF_FFFC, 4'd8, "R6 no wraparound");
        acc(3'd3, 5'd5, 64'hFFFF_FFFF_FFFF_FFF0, 4'd8, "R5 address wraps");
        // R3: fetch uses entry 1 and needs execute
        acc(3'd2, 5'd0, 64'h4, 4'd4, "R3 fetch without X");
        wr(5'd1, 64'h8000, 64'h1000, 3'b100);
        acc(3'd2, 5'd9, 64'h4, 4'd4, "R3 fetch ok");
        acc(3'd0, 5'd1, 64'h4, 4'd4, "R2 data does not use fetch entry");
        // R4: explicit selection including 0 and 1
        wr(5'd31, 64'hA000, 64'h40, 3'b001);
        acc(3'd3, 5'd31, 64'h8, 4'd2, "R4 seg load entry 31");
        acc(3'd3, 5'd1, 64'h8, 4'd2, "R4 seg load entry 1 lacks R");
        acc(3'd4, 5'd0, 64'h8, 4'd2, "R4 seg store entry 0");
        // R7: store needs W; perm beats bounds
        acc(3'd4, 5'd31, 64'h8, 4'd2, "R7 store without W");
        acc(3'd4, 5'd31, 64'h100, 4'd8, "R7 perm before bounds");
        acc(3'd2, 5'd0, 64'h0, 4'd4, "R7 fetch on X-only ok");
        // R11: illegal kinds
        acc(3'd5, 5'd12, 64'h0, 4'd1, "R11 kind 5");
        acc(3'd7, 5'd3, 64'h0, 4'd1, "R11 kind 7");
        // R9: same-cycle write sees old contents, next cycle new
        step(1, 5'd0, 64'h2000, 64'h10, 3'b001, 1, 3'd1, 5'd0, 64'h0, 4'd4, "R9 same cycle old");
        acc(3'd1, 5'd0, 64'h0, 4'd4, "R9 new contents");
        acc(3'd0, 5'd0, 64'h8, 4'd8, "R9 R8 new base");
        // R10: idle cycles quiet
        idle("R10 idle 1");
        idle("R10 idle 2");
        acc(3'd0, 5'd0, 64'h9, 4'd8, "R8 bounds fault idx");
        idle("R10 idle 3");
        idle("R10 drain");
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule